// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the internal controller that carries out single-location programs and whole-block erases on a behavioural flash array. Commands reach it already decoded, each with an address and a data word. A supply-valid flag reports whether the write supply is usable. Programming can only clear bits. Each program pulse clears one more of the bits that still differ from the target, and every pulse is followed by a verify of that location. If the attempt count reaches a limit without a clean verify, the operation fails.

An erase runs in two phases. First, every location of the addressed block is programmed to all zeros, so that no cell is erased from an uneven starting point. Then erase pulses are applied to the whole block. Each erase pulse moves every cell one step towards all ones, and a verify pass walks the block after each pulse. An erase may be suspended. The suspend takes effect at the next pulse boundary, and a resume continues from the saved location and phase. An 8-bit status byte reports readiness, suspension and three sticky error flags. A separate read port shows the array contents at any time.

Top module: `fpe_core`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces status to 0x80, returns the sequencer to idle with no pending work, and loads every array word with all ones.
- R2: A program command accepted while idle clears one excess bit (a bit set in the cell but clear in the target) per pulse, and verifies after each pulse. Busy lasts exactly 2 cycles per excess bit, after which the word equals the target and status is 0x80.
- R3: If the target has a bit set where the cell holds zero, the program stops after PROG_LIMIT pulses (2*PROG_LIMIT busy cycles). Status bit 4 (write error) is then set, and the word holds cell AND target.
- R4: An erase command leaves every word of the addressed block (block = address bits above BLK_W) at all ones and status 0x80. Words in other blocks are unchanged.
- R5: During an erase, the pre-write phase drives each block word to zero in ascending address order before any erase pulse is applied.
- R6: Status layout: bit 7 ready (1 when idle or suspended), bit 6 erase suspended, bit 5 erase error, bit 4 write error, bit 3 supply error, bits 2..0 always zero. While an operation runs with no error flags set, status reads 0x00.
- R7: A suspend command during an erase suspends at the next pulse boundary (at most 2 cycles later). Status then reads 0xC0 and the array does not change. A resume command continues the erase to completion.
- R8: If supply_ok is low when a pulse is due, no pulse is applied and the operation ends. Status bit 3 is set together with bit 4 (program) or bit 5 (erase).
- R9: Error bits are sticky across later operations. A clear-status command clears them only when ready is 1, and is ignored while busy.
- R10: Program and erase commands are ignored unless the sequencer is idle, suspend is ignored outside an erase, and resume is ignored unless suspended. Command codes: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear status.
- R11: If an erase verify still fails after ERASE_LIMIT erase pulses, the erase ends with status bit 5 set and the block left partly erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset / power-down |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Decoded command code |
| cmd_addr | input | ADDR_W | Word address (program) or any address inside the block (erase) |
| cmd_data | input | DATA_W | Program target value |
| supply_ok | input | 1 | Write supply within range |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at rd_addr (combinational) |
| status | output | 8 | Status byte |

## Verification
The checker assumes that reset is low from time zero and that a command strobe lasts one cycle. It also assumes that the read address is held steady whenever the bench wants frozen array contents compared between cycles. The stimulus drives every input on the falling clock edge, pulses cmd_valid for exactly one cycle, and changes rd_addr only between separate reads. Supply loss is injected only before a command is issued, so the abort point is always the first pulse and the expected array contents stay exact.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef enum logic [2:0] {
      CMD_NONE   = 3'd0,
      CMD_PROG   = 3'd1,
      CMD_ERASE  = 3'd2,
      CMD_SUSP   = 3'd3,
      CMD_RESUME = 3'd4,
      CMD_CLR    = 3'd5
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PG_PULSE,
      ST_PG_VERIFY,
      ST_PW_PULSE,
      ST_PW_VERIFY,
      ST_ER_PULSE,
      ST_ER_VERIFY,
      ST_SUSP
   } seq_state_e;

   typedef enum logic [1:0] {
      PULSE_NONE,
      PULSE_PROG,
      PULSE_ERASE
   } pulse_e;

   localparam int SR_READY = 7;
   localparam int SR_SUSP  = 6;
   localparam int SR_EERR  = 5;
   localparam int SR_WERR  = 4;
   localparam int SR_VERR  = 3;

endpackage

// File: rtl/fpe_array.sv
module fpe_array
   import fpe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int BLK_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pulse_e            pulse,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DATA_W-1:0] p_target,
   input  logic [ADDR_W-1:0] vfy_addr,
   output logic [DATA_W-1:0] vfy_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      logic [DATA_W-1:0] cell_q;
      logic [DATA_W-1:0] excess;
      logic [DATA_W-1:0] low_bit;

      assign excess  = cell_q & ~p_target;
      assign low_bit = excess & (~excess + DATA_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '1;
         end else if (pulse == PULSE_PROG && p_addr == MY_ADDR) begin
            cell_q <= cell_q & ~low_bit;
         end else if (pulse == PULSE_ERASE &&
                      p_addr[ADDR_W-1:BLK_W] == MY_ADDR[ADDR_W-1:BLK_W]) begin
            cell_q <= cell_q | (cell_q + DATA_W'(1));
         end
      end

      assign word_w[i] = cell_q;
   end

   assign vfy_data = word_w[vfy_addr];
   assign rd_data  = word_w[rd_addr];

endmodule

// File: rtl/fpe_status.sv
module fpe_status
   import fpe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready,
   input  logic       susp,
   input  logic       set_werr,
   input  logic       set_eerr,
   input  logic       set_verr,
   input  logic       clr,
   output logic [7:0] status_o
);

   logic eerr_q, werr_q, verr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eerr_q <= 1'b0;
         werr_q <= 1'b0;
         verr_q <= 1'b0;
      end else if (clr) begin
         eerr_q <= 1'b0;
         werr_q <= 1'b0;
         verr_q <= 1'b0;
      end else begin
         eerr_q <= eerr_q | set_eerr;
         werr_q <= werr_q | set_werr;
         verr_q <= verr_q | set_verr;
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[SR_READY] = ready;
      status_o[SR_SUSP]  = susp;
      status_o[SR_EERR]  = eerr_q;
      status_o[SR_WERR]  = werr_q;
      status_o[SR_VERR]  = verr_q;
   end

endmodule

// File: rtl/fpe_seq.sv
module fpe_seq
   import fpe_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int BLK_W       = 3,
   parameter int PROG_LIMIT  = 8,
   parameter int ERASE_LIMIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              supply_ok,
   input  logic [DATA_W-1:0] vfy_data,
   output pulse_e            pulse,
   output logic [ADDR_W-1:0] p_addr,
   output logic [DATA_W-1:0] p_target,
   output logic              ready,
   output logic              susp,
   output logic              set_werr,
   output logic              set_eerr,
   output logic              set_verr,
   output logic              clr
);

   localparam int LIM_MAX = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
   localparam int ATT_W   = $clog2(LIM_MAX + 1);
   localparam logic [ATT_W-1:0] PG_LIM = ATT_W'(PROG_LIMIT);
   localparam logic [ATT_W-1:0] ER_LIM = ATT_W'(ERASE_LIMIT);

   seq_state_e        state, state_d, resume_st, resume_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] data_q, data_d;
   logic [ATT_W-1:0]  att, att_d;
   logic              pend_q, pend_d;
   logic              in_erase, last_word;

   function automatic logic is_cmd(input logic v, input logic [2:0] c, input cmd_e k);
      return v && (c == k);
   endfunction

   assign in_erase  = (state == ST_PW_PULSE) || (state == ST_PW_VERIFY) ||
                      (state == ST_ER_PULSE) || (state == ST_ER_VERIFY);
   assign last_word = &addr_q[BLK_W-1:0];
   assign ready     = (state == ST_IDLE) || (state == ST_SUSP);
   assign susp      = (state == ST_SUSP);
   assign clr       = ready && is_cmd(cmd_valid, cmd_code, CMD_CLR);
   assign p_addr    = addr_q;
   assign p_target  = (state == ST_PW_PULSE) ? '0 : data_q;

   always_comb begin
      state_d  = state;
      resume_d = resume_st;
      addr_d   = addr_q;
      data_d   = data_q;
      att_d    = att;
      pend_d   = pend_q;
      pulse    = PULSE_NONE;
      set_werr = 1'b0;
      set_eerr = 1'b0;
      set_verr = 1'b0;
      if (in_erase && is_cmd(cmd_valid, cmd_code, CMD_SUSP)) pend_d = 1'b1;
      unique case (state)
         ST_IDLE: begin
            if (is_cmd(cmd_valid, cmd_code, CMD_PROG)) begin
               addr_d  = cmd_addr;
               data_d  = cmd_data;
               att_d   = '0;
               state_d = ST_PG_PULSE;
            end else if (is_cmd(cmd_valid, cmd_code, CMD_ERASE)) begin
               addr_d  = {cmd_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
               att_d   = '0;
               state_d = ST_PW_PULSE;
            end
         end
         ST_PG_PULSE: begin
            if (!supply_ok) begin
               set_verr = 1'b1;
               set_werr = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               pulse   = PULSE_PROG;
               att_d   = att + ATT_W'(1);
               state_d = ST_PG_VERIFY;
            end
         end
         ST_PG_VERIFY: begin
            if (vfy_data == data_q) begin
               state_d = ST_IDLE;
            end else if (att == PG_LIM) begin
               set_werr = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               state_d = ST_PG_PULSE;
            end
         end
         ST_PW_PULSE, ST_ER_PULSE: begin
            if (pend_q) begin
               resume_d = state;
               pend_d   = 1'b0;
               state_d  = ST_SUSP;
            end else if (!supply_ok) begin
               set_verr = 1'b1;
               set_eerr = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               pulse   = (state == ST_PW_PULSE) ? PULSE_PROG : PULSE_ERASE;
               att_d   = att + ATT_W'(1);
               state_d = (state == ST_PW_PULSE) ? ST_PW_VERIFY : ST_ER_VERIFY;
            end
         end
         ST_PW_VERIFY: begin
            if (vfy_data == '0) begin
               att_d = '0;
               if (last_word) begin
                  addr_d  = {addr_q[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
                  state_d = ST_ER_PULSE;
               end else begin
                  addr_d  = addr_q + ADDR_W'(1);
                  state_d = ST_PW_PULSE;
               end
            end else if (att == PG_LIM) begin
               set_eerr = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               state_d = ST_PW_PULSE;
            end
         end
         ST_ER_VERIFY: begin
            if (&vfy_data) begin
               if (last_word) state_d = ST_IDLE;
               else           addr_d  = addr_q + ADDR_W'(1);
            end else if (att == ER_LIM) begin
               set_eerr = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               state_d = ST_ER_PULSE;
            end
         end
         ST_SUSP: begin
            if (is_cmd(cmd_valid, cmd_code, CMD_RESUME)) state_d = resume_st;
         end
         default: state_d = ST_IDLE;
      endcase
      if (state_d == ST_IDLE) pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         resume_st <= ST_IDLE;
         addr_q    <= '0;
         data_q    <= '0;
         att       <= '0;
         pend_q    <= 1'b0;
      end else begin
         state     <= state_d;
         resume_st <= resume_d;
         addr_q    <= addr_d;
         data_q    <= data_d;
         att       <= att_d;
         pend_q    <= pend_d;
      end
   end

endmodule

// File: rtl/fpe_core.sv
module fpe_core
   import fpe_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int BLK_W       = 3,
   parameter int PROG_LIMIT  = 8,
   parameter int ERASE_LIMIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              supply_ok,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        status
);

   if (BLK_W < 1 || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("fpe_core: BLK_W must lie in 1..ADDR_W-1");
   end
   if (ADDR_W > 8) begin : g_bad_depth
      $error("fpe_core: ADDR_W above 8 makes the array model too large");
   end
   if (PROG_LIMIT < 1 || ERASE_LIMIT < 1) begin : g_bad_lim
      $error("fpe_core: attempt limits must be at least 1");
   end

   pulse_e            pulse;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_target;
   logic [DATA_W-1:0] vfy_data;
   logic              ready, susp, set_werr, set_eerr, set_verr, clr;

   fpe_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
      .PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .supply_ok(supply_ok), .vfy_data(vfy_data),
      .pulse(pulse), .p_addr(p_addr), .p_target(p_target),
      .ready(ready), .susp(susp),
      .set_werr(set_werr), .set_eerr(set_eerr), .set_verr(set_verr),
      .clr(clr)
   );

   fpe_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .pulse(pulse), .p_addr(p_addr), .p_target(p_target),
      .vfy_addr(p_addr), .vfy_data(vfy_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   fpe_status u_status (
      .clk(clk), .rst_n(rst_n),
      .ready(ready), .susp(susp),
      .set_werr(set_werr), .set_eerr(set_eerr), .set_verr(set_verr),
      .clr(clr), .status_o(status)
   );

endmodule

// File: rtl/fpe_core_chk.sv
module fpe_core_chk
   import fpe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_code,
   input logic              supply_ok,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [7:0]        status
);

   logic clr_now, resume_now, start_cmd;
   assign clr_now    = cmd_valid && cmd_code == CMD_CLR && status[SR_READY];
   assign resume_now = cmd_valid && cmd_code == CMD_RESUME;
   assign start_cmd  = cmd_valid && (cmd_code == CMD_PROG || cmd_code == CMD_ERASE ||
                                     cmd_code == CMD_RESUME);

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[2:0] == 3'b000); // R6

   AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
      status[SR_SUSP] |-> status[SR_READY]); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_now |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3]))); // R9

   AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (status[SR_SUSP] && !resume_now) |=> (!$stable(rd_addr) || $stable(rd_data))); // R7

   AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[SR_READY]) |-> $past(start_cmd)); // R10

   AST_SUPPLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SR_VERR]) |-> $past(!supply_ok)); // R8

endmodule

bind fpe_core fpe_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .supply_ok(supply_ok), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
);

// File: tb/fpe_core_bench.sv
module fpe_core_bench;

   localparam int AW = 6;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          supply_ok = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [7:0]    status;

   logic          t_cmd_valid = 1'b0;
   logic [2:0]    t_cmd_code = '0;
   logic [AW-1:0] t_cmd_addr = '0;
   logic [AW-1:0] t_rd_addr = '0;
   logic [DW-1:0] t_rd_data;
   logic [7:0]    t_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fpe_core u_fpe_core (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .supply_ok(supply_ok),
      .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
   );

   fpe_core #(.ERASE_LIMIT(4)) u_fpe_core_tight (
      .clk(clk), .rst_n(rst_n), .cmd_valid(t_cmd_valid), .cmd_code(t_cmd_code),
      .cmd_addr(t_cmd_addr), .cmd_data(8'h00), .supply_ok(1'b1),
      .rd_addr(t_rd_addr), .rd_data(t_rd_data), .status(t_status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = '0;
   endtask

   task automatic wait_ready(output int cyc);
      cyc = 0;
      while (!status[7] && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      chk("R1 status after reset", status, 8'h80);
      for (int a = 0; a < 64; a += 21) begin
         rd(AW'(a), d);
         chk("R1 erased word after reset", d, 8'hFF);
      end
   endtask

   task automatic t_program;
      int cyc;
      logic [DW-1:0] d;
      cmd(3'd1, 6'd9, 8'hA5);
      chk("R6 busy status", status, 8'h00);
      wait_ready(cyc);
      chk("R2 busy cycles FF->A5", cyc, 8);
      rd(6'd9, d);
      chk("R2 word after program", d, 8'hA5);
      chk("R2 status done", status, 8'h80);
      cmd(3'd1, 6'd9, 8'h21);
      wait_ready(cyc);
      chk("R2 busy cycles A5->21", cyc, 4);
      rd(6'd9, d);
      chk("R2 word after reprogram", d, 8'h21);
   endtask

   task automatic t_prog_fail;
      int cyc;
      logic [DW-1:0] d;
      cmd(3'd1, 6'd9, 8'h23);
      wait_ready(cyc);
      chk("R3 busy cycles on failure", cyc, 16);
      chk("R3 write error status", status, 8'h90);
      rd(6'd9, d);
      chk("R3 word kept", d, 8'h21);
      cmd(3'd1, 6'd10, 8'h0F);
      wait_ready(cyc);
      rd(6'd10, d);
      chk("R9 program works with error set", d, 8'h0F);
      chk("R9 error stays sticky", status, 8'h90);
      cmd(3'd1, 6'd13, 8'h00);
      repeat (3) @(negedge clk);
      cmd(3'd5, 6'd0, 8'h00);
      wait_ready(cyc);
      chk("R9 clear ignored while busy", status, 8'h90);
      cmd(3'd5, 6'd0, 8'h00);
      chk("R9 clear when ready", status, 8'h80);
   endtask

   task automatic t_ignore;
      int cyc;
      bit saw_susp;
      logic [DW-1:0] d;
      cmd(3'd1, 6'd11, 8'h00);
      repeat (2) @(negedge clk);
      cmd(3'd1, 6'd12, 8'h00);
      cmd(3'd3, 6'd0, 8'h00);
      saw_susp = 1'b0;
      cyc = 0;
      while (!status[7] && cyc < 100) begin
         if (status[6]) saw_susp = 1'b1;
         @(negedge clk);
         cyc++;
      end
      chk("R10 suspend ignored during program", saw_susp, 0);
      rd(6'd12, d);
      chk("R10 program ignored while busy", d, 8'hFF);
      rd(6'd11, d);
      chk("R10 first program completed", d, 8'h00);
      cmd(3'd4, 6'd0, 8'h00);
      chk("R10 resume ignored when idle", status, 8'h80);
   endtask

   task automatic t_erase;
      int cyc;
      logic [DW-1:0] d;
      cmd(3'd1, 6'd7, 8'h55);
      wait_ready(cyc);
      cmd(3'd1, 6'd16, 8'h3C);
      wait_ready(cyc);
      cmd(3'd2, 6'd12, 8'h00);
      wait_ready(cyc);
      chk("R4 status after erase", status, 8'h80);
      for (int a = 8; a < 16; a++) begin
         rd(AW'(a), d);
         chk("R4 block word erased", d, 8'hFF);
      end
      rd(6'd7, d);
      chk("R4 lower neighbour kept", d, 8'h55);
      rd(6'd16, d);
      chk("R4 upper neighbour kept", d, 8'h3C);
   endtask

   task automatic t_suspend;
      int cyc;
      int k;
      logic [DW-1:0] d, d2;
      cmd(3'd2, 6'd20, 8'h00);
      repeat (18) @(negedge clk);
      cmd(3'd3, 6'd0, 8'h00);
      k = 0;
      while (!status[6] && k < 10) begin
         @(negedge clk);
         k++;
      end
      chk("R7 suspend at next pulse boundary", int'(k <= 2), 1);
      chk("R7 suspended status", status, 8'hC0);
      rd(6'd16, d);
      chk("R5 first word pre-written", d, 8'h00);
      rd(6'd23, d);
      chk("R5 last word not yet touched", d, 8'hFF);
      rd(6'd17, d);
      repeat (6) @(negedge clk);
      rd(6'd17, d2);
      chk("R7 array frozen while suspended", d2, d);
      cmd(3'd1, 6'd40, 8'h00);
      chk("R10 program ignored while suspended", status, 8'hC0);
      cmd(3'd4, 6'd0, 8'h00);
      chk("R7 busy after resume", status, 8'h00);
      wait_ready(cyc);
      chk("R7 status after resumed erase", status, 8'h80);
      for (int a = 16; a < 24; a++) begin
         rd(AW'(a), d);
         chk("R7 resumed block erased", d, 8'hFF);
      end
      rd(6'd40, d);
      chk("R10 ignored program left word", d, 8'hFF);
   endtask

   task automatic t_supply;
      int cyc;
      logic [DW-1:0] d;
      supply_ok = 1'b0;
      cmd(3'd1, 6'd30, 8'h00);
      wait_ready(cyc);
      chk("R8 program abort cycles", cyc, 1);
      chk("R8 program supply status", status, 8'h98);
      rd(6'd30, d);
      chk("R8 no program pulse", d, 8'hFF);
      supply_ok = 1'b1;
      cmd(3'd5, 6'd0, 8'h00);
      cmd(3'd1, 6'd41, 8'h12);
      wait_ready(cyc);
      supply_ok = 1'b0;
      cmd(3'd2, 6'd41, 8'h00);
      wait_ready(cyc);
      chk("R8 erase supply status", status, 8'hA8);
      rd(6'd41, d);
      chk("R8 no erase pulse", d, 8'h12);
      supply_ok = 1'b1;
      cmd(3'd5, 6'd0, 8'h00);
      chk("R9 clear after supply error", status, 8'h80);
   endtask

   task automatic t_limit;
      int k;
      logic [DW-1:0] d;
      chk("R1 tight instance reset status", t_status, 8'h80);
      @(negedge clk);
      t_cmd_valid = 1'b1; t_cmd_code = 3'd2; t_cmd_addr = 6'd3;
      @(negedge clk);
      t_cmd_valid = 1'b0; t_cmd_code = '0;
      k = 0;
      while (!t_status[7] && k < 2000) begin
         @(negedge clk);
         k++;
      end
      chk("R11 erase error at limit", t_status, 8'hA0);
      t_rd_addr = 6'd0;
      #1;
      d = t_rd_data;
      chk("R11 block left partly erased", d, 8'h0F);
      t_rd_addr = 6'd8;
      #1;
      d = t_rd_data;
      chk("R11 other block untouched", d, 8'hFF);
   endtask

   task automatic t_reset_mid;
      logic [DW-1:0] d;
      int bad;
      cmd(3'd2, 6'd26, 8'h00);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 status during reset", status, 8'h80);
      @(negedge clk);
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (status != 8'h80) bad++;
      end
      chk("R1 idle after reset", bad, 0);
      rd(6'd24, d);
      chk("R1 array erased by reset", d, 8'hFF);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_program;
      t_prog_fail;
      t_ignore;
      t_erase;
      t_suspend;
      t_supply;
      t_limit;
      t_reset_mid;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule